// File: doc/BRIEF.md
# Execute-Packet Splitter for a Wide-Issue Instruction Front End

This block sits between instruction fetch and dispatch in a very-long-instruction-word core. It takes one fetch packet at a time, eight 32-bit words wide, and breaks it into execute packets. An execute packet is a run of instructions that dispatch issues together in one cycle. The split follows a chaining bit in each instruction. Bit 0 set means the next instruction joins the same group. Bit 0 clear closes the group.

A fetch packet may instead start with a header in its top word. That header marks which of the other seven words each hold two 16-bit compact instructions. It also carries one chaining bit for each 16-bit half. The block expands each compact half into its own 32-bit slot and forms the groups from those chaining bits.

Execute packets leave the block as a slot array with a valid mask, a compact mask and a count. Transfer uses a valid/ready handshake, at most one group per cycle. The block holds the fetch side stalled until the last group of the current packet has been taken.

Top module: `fp_ep_splitter`

## Requirements
- R1: A cycle after a synchronous active-high reset, `ep_valid` is 0 and `fp_ready` is 1.
- R2: In a plain packet (word 7 bits [31:28] not equal to 4'hE), the instructions are words 0 to 7 in word order. A group ends after an instruction whose bit 0 is 0. The first instruction of a group is in slot 0 and the rest follow in order.
- R3: A group never spans two fetch packets. The last instruction of a packet closes its group even when its chaining bit is 1.
- R4: A plain packet in which every bit 0 is 1 gives a single group of 8, with `ep_count` = 8.
- R5: A packet whose word 7 has bits [31:28] = 4'hE is a header packet. Only words 0 to 6 carry instructions, and the header word itself never appears in a slot.
- R6: In a header packet, bit i of word 7 (i = 0..6) set marks word i as compact. Word i then yields two slots in this order: bits [15:0] first, then bits [31:16]. Each slot is zero-extended to 32 bits and has its `ep_compact` bit set. A word that is not compact yields one slot with its `ep_compact` bit clear.
- R7: In a header packet, the chaining bit of the low half of compact word i is word 7 bit 7+2i, and that of its high half is bit 8+2i. A word that is not compact in a header packet uses its own bit 0.
- R8: While `ep_valid` is 1, `ep_mask` has exactly its low `ep_count` bits set and `ep_compact` is a subset of `ep_mask`. Slots outside the mask read as zero.
- R9: While `ep_valid` is 1 and `ep_ready` is 0, the slots, masks and count stay unchanged.
- R10: `fp_ready` is 0 while a packet is held. It returns to 1 in the cycle after the last group is accepted. A packet is captured only when `fp_valid` and `fp_ready` are both 1. The first group is offered in the next cycle.
- R11: A reset asserted while a packet is only partly consumed discards the rest of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Block can take a fetch packet |
| fp_data | input | 256 | Fetch packet; word i is bits [32i+31:32i] |
| ep_valid | output | 1 | An execute packet is presented |
| ep_ready | input | 1 | Dispatch takes the presented execute packet |
| ep_slots | output | 480 | Slot k is bits [32k+31:32k], slot 0 first |
| ep_mask | output | 15 | Per-slot valid |
| ep_compact | output | 15 | Per-slot flag: slot holds an expanded 16-bit instruction |
| ep_count | output | 4 | Number of valid slots |

## Verification
A wrong read pointer or a wrong group-end decision shows up at once. The very next group presented has the wrong count or the wrong first slot, and every later group of that packet is misaligned too. A wrong busy flag shows up within a cycle in one of two ways: `fp_ready` rises while groups are still pending, or the packet never drains. The bench's behavioural model predicts each presented group and both ready/valid levels for every clock. Any divergence is therefore caught in the cycle it first appears, including during stalls and across a reset in mid-packet.

// File: rtl/fpsplit_pkg.sv
`timescale 1ns/1ps
package fpsplit_pkg;

   // Depth of the unpacked instruction list: the larger of a plain packet
   // and a fully compact header packet (two halves per non-header word).
   function automatic int unsigned list_depth(input int unsigned words);
      int unsigned packed_n;
      packed_n = 2 * (words - 1);
      return (packed_n > words) ? packed_n : words;
   endfunction

endpackage

// File: rtl/fp_unpack.sv
`timescale 1ns/1ps
module fp_unpack #(
   parameter int unsigned FP_WORDS   = 8,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned TAG_W      = 4,
   parameter logic [TAG_W-1:0] HDR_TAG = 4'hE,
   parameter bit          COMPACT_EN = 1'b1,
   parameter int unsigned LDEPTH     = 14,
   parameter int unsigned PW         = 4
) (
   input  logic [FP_WORDS*WORD_W-1:0] words,
   output logic [LDEPTH*WORD_W-1:0]   lst_data,
   output logic [LDEPTH-1:0]          lst_cmp,
   output logic [LDEPTH-1:0]          lst_end,
   output logic [PW-1:0]              lst_n
);
   localparam int unsigned CW   = FP_WORDS - 1;
   localparam int unsigned TOPB = CW * WORD_W;
   localparam int unsigned HALF = WORD_W / 2;

   logic              hdr;
   logic [LDEPTH-1:0] par;

   generate
      if (COMPACT_EN) begin : g_hdr_detect
         assign hdr = (words[FP_WORDS*WORD_W-1 -: TAG_W] == HDR_TAG);
      end else begin : g_plain_only
         assign hdr = 1'b0;
      end
   endgenerate

   // Build the ordered instruction list with per-entry chaining bits.
   always_comb begin
      int pos;
      pos      = 0;
      lst_data = '0;
      lst_cmp  = '0;
      par      = '0;
      if (hdr) begin
         for (int i = 0; i < CW; i++) begin
            if (words[TOPB+i]) begin
               lst_data[pos*WORD_W +: WORD_W] = {{HALF{1'b0}}, words[i*WORD_W +: HALF]};
               lst_cmp[pos] = 1'b1;
               par[pos]     = words[TOPB+CW+2*i];
               pos++;
               lst_data[pos*WORD_W +: WORD_W] = {{HALF{1'b0}}, words[i*WORD_W+HALF +: HALF]};
               lst_cmp[pos] = 1'b1;
               par[pos]     = words[TOPB+CW+2*i+1];
               pos++;
            end else begin
               lst_data[pos*WORD_W +: WORD_W] = words[i*WORD_W +: WORD_W];
               par[pos] = words[i*WORD_W];
               pos++;
            end
         end
      end else begin
         for (int i = 0; i < FP_WORDS; i++) begin
            lst_data[i*WORD_W +: WORD_W] = words[i*WORD_W +: WORD_W];
            par[i] = words[i*WORD_W];
         end
         pos = FP_WORDS;
      end
      lst_n = PW'(pos);
   end

   // A group closes on a clear chaining bit or at the last list entry.
   always_comb begin
      for (int k = 0; k < LDEPTH; k++) begin
         lst_end[k] = !par[k] || ((k + 1) == int'(lst_n));
      end
   end

endmodule

// File: rtl/ep_select.sv
`timescale 1ns/1ps
module ep_select #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned LDEPTH    = 14,
   parameter int unsigned PW        = 4,
   parameter int unsigned OUT_SLOTS = 15,
   parameter int unsigned CNT_W     = 4
) (
   input  logic [PW-1:0]               ptr,
   input  logic [LDEPTH*WORD_W-1:0]    lst_data,
   input  logic [LDEPTH-1:0]           lst_cmp,
   input  logic [LDEPTH-1:0]           lst_end,
   input  logic [PW-1:0]               lst_n,
   output logic [OUT_SLOTS*WORD_W-1:0] slot_data,
   output logic [OUT_SLOTS-1:0]        slot_mask,
   output logic [OUT_SLOTS-1:0]        slot_cmp,
   output logic [CNT_W-1:0]            slot_cnt,
   output logic [PW-1:0]               nxt_ptr,
   output logic                        last_grp
);
   int cnt_i;

   // Gather entries from ptr up to and including the first group end.
   always_comb begin
      logic stop;
      int   idx;
      stop      = 1'b0;
      cnt_i     = 0;
      slot_data = '0;
      slot_mask = '0;
      slot_cmp  = '0;
      for (int k = 0; k < OUT_SLOTS; k++) begin
         idx = int'(ptr) + k;
         if (!stop && (idx < int'(lst_n))) begin
            slot_data[k*WORD_W +: WORD_W] = lst_data[idx*WORD_W +: WORD_W];
            slot_mask[k] = 1'b1;
            slot_cmp[k]  = lst_cmp[idx];
            stop         = lst_end[idx];
            cnt_i++;
         end
      end
   end

   assign slot_cnt = CNT_W'(cnt_i);
   assign nxt_ptr  = PW'(int'(ptr) + cnt_i);
   assign last_grp = (int'(ptr) + cnt_i) >= int'(lst_n);

endmodule

// File: rtl/pkt_ctrl.sv
`timescale 1ns/1ps
module pkt_ctrl #(
   parameter int unsigned FP_WORDS = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned PW       = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       fp_valid,
   input  logic [FP_WORDS*WORD_W-1:0] fp_data,
   input  logic                       ep_ready,
   input  logic [PW-1:0]              nxt_ptr,
   input  logic                       last_grp,
   output logic                       fp_ready,
   output logic                       loaded,
   output logic [PW-1:0]              ptr_q,
   output logic [FP_WORDS*WORD_W-1:0] words_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         loaded <= 1'b0;
         ptr_q  <= '0;
      end else if (!loaded) begin
         if (fp_valid) begin
            loaded  <= 1'b1;
            words_q <= fp_data;
            ptr_q   <= '0;
         end
      end else if (ep_ready) begin
         if (last_grp) begin
            loaded <= 1'b0;
            ptr_q  <= '0;
         end else begin
            ptr_q <= nxt_ptr;
         end
      end
   end

   assign fp_ready = !loaded;

   // R9: a stalled group keeps its source packet and position
   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
      (loaded && !ep_ready) |=> (loaded && $stable(ptr_q) && $stable(words_q)));

   // R10: fetch reopens right after the final group leaves
   a_r10_reopen_after_last: assert property (@(posedge clk) disable iff (rst)
      (loaded && ep_ready && last_grp) |=> fp_ready);

   // R2: a non-final accepted group moves the read position forward
   a_r2_ptr_advance: assert property (@(posedge clk) disable iff (rst)
      (loaded && ep_ready && !last_grp) |=> (loaded && (ptr_q > $past(ptr_q))));

endmodule

// File: rtl/fp_ep_splitter.sv
`timescale 1ns/1ps
module fp_ep_splitter #(
   parameter int unsigned FP_WORDS   = 8,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned OUT_SLOTS  = 15,
   parameter int unsigned TAG_W      = 4,
   parameter logic [TAG_W-1:0] HDR_TAG = 4'hE,
   parameter bit          COMPACT_EN = 1'b1,
   parameter int unsigned CNT_W      = $clog2(OUT_SLOTS + 1)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        fp_valid,
   output logic                        fp_ready,
   input  logic [FP_WORDS*WORD_W-1:0]  fp_data,
   output logic                        ep_valid,
   input  logic                        ep_ready,
   output logic [OUT_SLOTS*WORD_W-1:0] ep_slots,
   output logic [OUT_SLOTS-1:0]        ep_mask,
   output logic [OUT_SLOTS-1:0]        ep_compact,
   output logic [CNT_W-1:0]            ep_count
);
   localparam int unsigned LDEPTH = fpsplit_pkg::list_depth(FP_WORDS);
   localparam int unsigned PW     = $clog2(LDEPTH + 1);
   localparam int unsigned CW     = FP_WORDS - 1;

   initial begin : elab_checks
      assert (OUT_SLOTS >= LDEPTH)
         else $fatal(1, "slot vector narrower than the instruction list");
      assert (3 * CW + TAG_W <= WORD_W)
         else $fatal(1, "header fields do not fit in one word");
      assert ((WORD_W % 2) == 0)
         else $fatal(1, "word width must split into two halves");
      assert (CNT_W >= $clog2(OUT_SLOTS + 1))
         else $fatal(1, "count field too narrow");
   end

   logic                       loaded;
   logic [PW-1:0]              ptr_q;
   logic [FP_WORDS*WORD_W-1:0] words_q;
   logic [LDEPTH*WORD_W-1:0]   lst_data;
   logic [LDEPTH-1:0]          lst_cmp;
   logic [LDEPTH-1:0]          lst_end;
   logic [PW-1:0]              lst_n;
   logic [PW-1:0]              nxt_ptr;
   logic                       last_grp;
   logic [OUT_SLOTS*WORD_W-1:0] sel_data;
   logic [OUT_SLOTS-1:0]        sel_mask;
   logic [OUT_SLOTS-1:0]        sel_cmp;
   logic [CNT_W-1:0]            sel_cnt;

   pkt_ctrl #(.FP_WORDS(FP_WORDS), .WORD_W(WORD_W), .PW(PW)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .fp_valid (fp_valid),
      .fp_data  (fp_data),
      .ep_ready (ep_ready),
      .nxt_ptr  (nxt_ptr),
      .last_grp (last_grp),
      .fp_ready (fp_ready),
      .loaded   (loaded),
      .ptr_q    (ptr_q),
      .words_q  (words_q)
   );

   fp_unpack #(
      .FP_WORDS(FP_WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .HDR_TAG(HDR_TAG),
      .COMPACT_EN(COMPACT_EN), .LDEPTH(LDEPTH), .PW(PW)
   ) u_unpack (
      .words    (words_q),
      .lst_data (lst_data),
      .lst_cmp  (lst_cmp),
      .lst_end  (lst_end),
      .lst_n    (lst_n)
   );

   ep_select #(
      .WORD_W(WORD_W), .LDEPTH(LDEPTH), .PW(PW), .OUT_SLOTS(OUT_SLOTS), .CNT_W(CNT_W)
   ) u_select (
      .ptr       (ptr_q),
      .lst_data  (lst_data),
      .lst_cmp   (lst_cmp),
      .lst_end   (lst_end),
      .lst_n     (lst_n),
      .slot_data (sel_data),
      .slot_mask (sel_mask),
      .slot_cmp  (sel_cmp),
      .slot_cnt  (sel_cnt),
      .nxt_ptr   (nxt_ptr),
      .last_grp  (last_grp)
   );

   assign ep_valid   = loaded;
   assign ep_slots   = sel_data;
   assign ep_mask    = sel_mask;
   assign ep_compact = sel_cmp;
   assign ep_count   = sel_cnt;

   // R1: reset leaves the block empty and open to fetch
   a_r1_idle_after_reset: assert property (@(posedge clk)
      $past(rst) |-> (!ep_valid && fp_ready));

   // R3: every presented group carries at least one instruction in slot 0
   a_r3_group_nonempty: assert property (@(posedge clk) disable iff (rst)
      ep_valid |-> ((ep_count != '0) && ep_mask[0]));

   // R8: compact flags only on valid slots
   a_r8_compact_in_mask: assert property (@(posedge clk) disable iff (rst)
      ep_valid |-> ((ep_compact & ~ep_mask) == '0));

   // R10: fetch and execute sides are never open together
   a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(ep_valid && fp_ready));

endmodule

// File: tb/tb_fp_ep_splitter.sv
`timescale 1ns/1ps
module tb_fp_ep_splitter;
   localparam int NW = 8;
   localparam int WW = 32;
   localparam int NS = 15;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst = 1'b1;
   logic              fp_valid = 1'b0;
   logic              fp_ready;
   logic [NW*WW-1:0]  fp_data = '0;
   logic              ep_valid;
   logic              ep_ready = 1'b0;
   logic [NS*WW-1:0]  ep_slots;
   logic [NS-1:0]     ep_mask;
   logic [NS-1:0]     ep_compact;
   logic [3:0]        ep_count;

   fp_ep_splitter dut (
      .clk(clk), .rst(rst), .fp_valid(fp_valid), .fp_ready(fp_ready),
      .fp_data(fp_data), .ep_valid(ep_valid), .ep_ready(ep_ready),
      .ep_slots(ep_slots), .ep_mask(ep_mask), .ep_compact(ep_compact),
      .ep_count(ep_count)
   );

   typedef struct packed {
      logic [NS*WW-1:0] d;
      logic [NS-1:0]    m;
      logic [NS-1:0]    c;
      logic [3:0]       n;
   } ep_t;

   ep_t mq[$];
   bit  mdl_loaded = 1'b0;
   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   // Behavioural model: list of instructions, then groups from chaining bits.
   function automatic void build(input logic [NW*WW-1:0] w);
      logic [31:0] id[$];
      bit          ic[$];
      bit          ip[$];
      logic [31:0] hw;
      ep_t         e;
      hw = w[7*32 +: 32];
      if (hw[31:28] == 4'hE) begin
         for (int i = 0; i < 7; i++) begin
            logic [31:0] x;
            x = w[i*32 +: 32];
            if (hw[i]) begin
               id.push_back({16'h0, x[15:0]});  ic.push_back(1); ip.push_back(hw[7+2*i]);
               id.push_back({16'h0, x[31:16]}); ic.push_back(1); ip.push_back(hw[8+2*i]);
            end else begin
               id.push_back(x); ic.push_back(0); ip.push_back(x[0]);
            end
         end
      end else begin
         for (int i = 0; i < 8; i++) begin
            id.push_back(w[i*32 +: 32]); ic.push_back(0); ip.push_back(w[i*32]);
         end
      end
      e = '0;
      for (int k = 0; k < id.size(); k++) begin
         e.d[int'(e.n)*32 +: 32] = id[k];
         e.m[e.n] = 1'b1;
         e.c[e.n] = ic[k];
         e.n = e.n + 4'd1;
         if (!ip[k] || (k == id.size() - 1)) begin
            mq.push_back(e);
            e = '0;
         end
      end
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         mq.delete();
         mdl_loaded = 1'b0;
      end else if (mdl_loaded) begin
         if (ep_ready) begin
            void'(mq.pop_front());
            if (mq.size() == 0) mdl_loaded = 1'b0;
         end
      end else if (fp_valid) begin
         build(fp_data);
         mdl_loaded = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [511:0] act,
                      input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(ep_valid === mdl_loaded, {"R10 ep_valid ", tag}, 512'(ep_valid), 512'(mdl_loaded));
      chk(fp_ready === !mdl_loaded, {"R10 fp_ready ", tag}, 512'(fp_ready), 512'(!mdl_loaded));
      if (mdl_loaded && mq.size() > 0) begin
         chk(ep_count === mq[0].n, {"R2 count ", tag}, 512'(ep_count), 512'(mq[0].n));
         chk(ep_mask === mq[0].m, {"R8 mask ", tag}, 512'(ep_mask), 512'(mq[0].m));
         chk(ep_compact === mq[0].c, {"R6 compact ", tag}, 512'(ep_compact), 512'(mq[0].c));
         chk(ep_slots === mq[0].d, {"R7 slots ", tag}, 512'(ep_slots), 512'(mq[0].d));
      end
   endtask

   task automatic cyc(input string tag);
      @(negedge clk);
      compare(tag);
   endtask

   // Offer one packet, then drain it; exp_first >= 0 checks the first group size.
   task automatic send(input logic [NW*WW-1:0] w, input string tag, input int exp_first,
                       input bit stalls);
      while (mdl_loaded) begin ep_ready = 1'b1; cyc(tag); end
      fp_valid = 1'b1; fp_data = w; ep_ready = 1'b0;
      cyc(tag);
      fp_valid = 1'b0;
      if (exp_first >= 0)
         chk(int'(ep_count) == exp_first, {"first group size ", tag},
             512'(ep_count), 512'(exp_first));
      while (mdl_loaded) begin
         ep_ready = stalls ? (($urandom % 3) != 0) : 1'b1;
         cyc(tag);
      end
      ep_ready = 1'b0;
   endtask

   function automatic logic [NW*WW-1:0] plain_pkt(input logic [7:0] pbits);
      logic [NW*WW-1:0] w;
      for (int i = 0; i < 8; i++) w[i*32 +: 32] = {24'h10 + 24'(i), 7'h11, pbits[i]};
      return w;
   endfunction

   task automatic finish_report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R10 actual=hung expected=done");
         finish_report();
      end
   end

   initial begin
      logic [NW*WW-1:0] w;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(ep_valid === 1'b0, "R1 ep_valid after reset", 512'(ep_valid), 512'(0));
      chk(fp_ready === 1'b1, "R1 fp_ready after reset", 512'(fp_ready), 512'(1));
      cyc("R1");

      // R4: all chained -> one group of 8
      send(plain_pkt(8'hFF), "R4", 8, 1'b0);
      // R3: bits 1,1,0 then all 1: groups of 3 and 5, the last closed by the boundary
      send(plain_pkt(8'b1111_1011), "R3", 3, 1'b0);
      // R2: every instruction alone
      send(plain_pkt(8'h00), "R2", 1, 1'b0);
      // R2: mixed pattern with stalls (R9)
      send(plain_pkt(8'b0101_1001), "R9", 2, 1'b1);

      // R5/R6/R7: words 0 and 1 compact; slot chaining 1,1,0,1; word2 bit0=1, rest 0
      w = '0;
      for (int i = 0; i < 7; i++) w[i*32 +: 32] = {16'hA000 + 16'(i), 16'hB000 + 16'(i*2)};
      w[2*32] = 1'b1;
      w[7*32 +: 32] = {4'hE, 7'h0, 14'b00_0000_0000_1011, 7'b000_0011};
      send(w, "R5", 3, 1'b0);
      send(w, "R6", 3, 1'b1);
      // R7: all compact, all halves chained -> one group of 14
      w[7*32 +: 32] = {4'hE, 7'h0, 14'h3FFF, 7'h7F};
      send(w, "R7", 14, 1'b0);

      // R11: reset during a partly consumed packet
      fp_valid = 1'b1; fp_data = plain_pkt(8'h00); ep_ready = 1'b0;
      cyc("R11");
      fp_valid = 1'b0; ep_ready = 1'b1;
      cyc("R11");
      ep_ready = 1'b0;
      rst = 1'b1;
      cyc("R11");
      rst = 1'b0;
      chk(ep_valid === 1'b0, "R11 ep_valid after mid-packet reset", 512'(ep_valid), 512'(0));
      chk(fp_ready === 1'b1, "R11 fp_ready after mid-packet reset", 512'(fp_ready), 512'(1));
      cyc("R11");

      // R8: random plain and header packets with random stalls
      for (int p = 0; p < 400; p++) begin
         for (int i = 0; i < 8; i++) w[i*32 +: 32] = $urandom;
         if (($urandom % 10) < 4) w[7*32 + 28 +: 4] = 4'hE;
         else if (w[7*32 + 28 +: 4] == 4'hE) w[7*32 + 28 +: 4] = 4'h3;
         send(w, "R8", -1, 1'b1);
      end

      finished = 1'b1;
      finish_report();
   end
endmodule